// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter Stage

This block is a small presettable binary counter (4 bits by default) that counts up or down. Every register changes only on the rising clock edge. A low level on the active-low load input copies the parallel data word into the count at the next edge. Otherwise the count steps by one in the direction set by the direction input. It steps only when both active-low count enables are low. There is no asynchronous clear, so the count is defined once the first load has taken place.

At each edge the stage picks one of four operating modes from its control levels: MODE_LOAD, MODE_UP, MODE_DOWN or MODE_HOLD. The transitions are these:
- load low goes to MODE_LOAD;
- load high with both enables low goes to MODE_UP or MODE_DOWN, following the direction input;
- load high with either enable high goes to MODE_HOLD.

The mode is recomputed at every edge from the current levels, so any mode can follow any other.

An active-low carry output flags the terminal count for the current direction: all ones when counting up, zero when counting down. Only the carry-side enable gates this output. The carry reacts combinationally to that enable, to the direction input and to the count. Wider counters are built by feeding each stage's carry into the next stage's carry-side enable and sharing one count-side enable among all stages, with no extra gates.

Top module: `ctr_updown_stage`

## Requirements
- R1: When load_n is low at a rising edge, count equals din after that edge.
- R2: Load wins over the enables: load_n low loads din even when cnt_en_n or carry_en_n is high, and even when both are low.
- R3: With load_n high, cnt_en_n low, carry_en_n low and dir_up high (1), count increments by one at the edge.
- R4: With load_n high, both enables low and dir_up low (0), count decrements by one at the edge.
- R5: With load_n high and either cnt_en_n or carry_en_n high, count holds its value at the edge.
- R6: Counting wraps: up from all ones gives zero, down from zero gives all ones.
- R7: carry_n is low exactly when carry_en_n is low and the count is terminal for the present direction: 15 with dir_up=1, 0 with dir_up=0. It follows carry_en_n and dir_up with no clock edge.
- R8: Changes on load_n, din, the enables or dir_up between edges leave count unchanged until the next rising edge.
- R9: Two stages connected as follows form a synchronous 8-bit up/down counter: the low stage's carry_n drives the high stage's carry_en_n, and both stages share cnt_en_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all state |
| load_n | input | 1 | Active-low synchronous parallel load |
| din | input | WIDTH | Parallel data loaded into the count |
| cnt_en_n | input | 1 | Active-low count enable that does not gate the carry |
| carry_en_n | input | 1 | Active-low count enable that also gates carry_n |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| count | output | WIDTH | Current count value |
| carry_n | output | 1 | Active-low terminal-count carry |

## Verification
Every 8-bit value is loaded into a two-stage chain with the enables alternating high and low. This separates a correct load from load priority errors and from wrong bit ordering between the stages. Long up and down runs cross every nibble boundary and the full wrap, which exposes carry propagation errors between the stages. Single-enable inhibit cycles tell the two enables apart. Between edges, the carry-side enable and the direction are toggled at counts 0 and 15 to confirm that the carry responds combinationally. The other controls are toggled between edges as well, to confirm that the count does not move.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD = 2'd0,
        MODE_LOAD = 2'd1,
        MODE_UP   = 2'd2,
        MODE_DOWN = 2'd3
    } ctr_mode_e;
endpackage

// File: rtl/ctr_mode_decode.sv
module ctr_mode_decode
    import ctr_pkg::*;
(
    input  logic      load_n,
    input  logic      cnt_en_n,
    input  logic      carry_en_n,
    input  logic      dir_up,
    output ctr_mode_e mode
);
    always_comb begin
        if (!load_n) begin
            mode = MODE_LOAD;
        end else if (!cnt_en_n && !carry_en_n) begin
            mode = dir_up ? MODE_UP : MODE_DOWN;
        end else begin
            mode = MODE_HOLD;
        end
    end
endmodule

// File: rtl/ctr_next_value.sv
module ctr_next_value
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  ctr_mode_e        mode,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    always_comb begin
        unique case (mode)
            MODE_LOAD: nxt = din;
            MODE_UP:   nxt = cur + STEP;
            MODE_DOWN: nxt = cur - STEP;
            MODE_HOLD: nxt = cur;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/ctr_carry_gen.sv
module ctr_carry_gen #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             carry_en_n,
    input  logic             dir_up,
    output logic             carry_n
);
    localparam logic [WIDTH-1:0] TOP_VAL = '1;
    localparam logic [WIDTH-1:0] BOT_VAL = '0;

    logic at_end;

    always_comb begin
        at_end  = dir_up ? (cur == TOP_VAL) : (cur == BOT_VAL);
        carry_n = !(at_end && !carry_en_n);
    end
endmodule

// File: rtl/ctr_updown_stage.sv
module ctr_updown_stage
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             cnt_en_n,
    input  logic             carry_en_n,
    input  logic             dir_up,
    output logic [WIDTH-1:0] count,
    output logic             carry_n
);
    localparam logic [WIDTH-1:0] TOP_VAL = '1;
    localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);

    ctr_mode_e        mode;
    logic [WIDTH-1:0] count_nxt;

    ctr_mode_decode u_decode (
        .load_n     (load_n),
        .cnt_en_n   (cnt_en_n),
        .carry_en_n (carry_en_n),
        .dir_up     (dir_up),
        .mode       (mode)
    );

    ctr_next_value #(.WIDTH(WIDTH)) u_next (
        .mode (mode),
        .cur  (count),
        .din  (din),
        .nxt  (count_nxt)
    );

    ctr_carry_gen #(.WIDTH(WIDTH)) u_carry (
        .cur        (count),
        .carry_en_n (carry_en_n),
        .dir_up     (dir_up),
        .carry_n    (carry_n)
    );

    // State register: the only storage in the stage.
    always_ff @(posedge clk) begin
        count <= count_nxt;
    end

    // Checks are held off until one edge has passed.
    logic primed = 1'b0;
    always_ff @(posedge clk) begin
        primed <= 1'b1;
    end

    a_r1_load_takes_data: assert property (@(posedge clk) disable iff (!primed)
        !load_n |=> count == $past(din));

    // R2: load overrides both enables.
    a_r2_load_beats_enables: assert property (@(posedge clk) disable iff (!primed)
        (!load_n && (cnt_en_n || carry_en_n)) |=> count == $past(din));

    a_r3_count_up: assert property (@(posedge clk) disable iff (!primed)
        (load_n && !cnt_en_n && !carry_en_n && dir_up)
        |=> count == WIDTH'($past(count) + ONE));

    a_r4_count_down: assert property (@(posedge clk) disable iff (!primed)
        (load_n && !cnt_en_n && !carry_en_n && !dir_up)
        |=> count == WIDTH'($past(count) - ONE));

    a_r5_hold: assert property (@(posedge clk) disable iff (!primed)
        (load_n && (cnt_en_n || carry_en_n)) |=> $stable(count));

    a_r6_wrap_up: assert property (@(posedge clk) disable iff (!primed)
        (load_n && !cnt_en_n && !carry_en_n && dir_up && count == TOP_VAL)
        |=> count == '0);

    a_r7_carry_gated: assert property (@(posedge clk) disable iff (!primed)
        !carry_n |-> (!carry_en_n && (dir_up ? count == TOP_VAL : count == '0)));
endmodule

// File: tb/ctr_updown_stage_test.sv
`timescale 1ns/100ps
module ctr_updown_stage_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       load_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic       enp_n = 1'b1;
    logic       ent_n = 1'b1;
    logic       dir_up = 1'b1;
    logic [3:0] lo_q, hi_q;
    logic       lo_carry_n, hi_carry_n;

    int         n_tests = 0;
    int         n_fail = 0;
    logic [7:0] model = 8'h00;
    bit         done = 1'b0;

    ctr_updown_stage #(.WIDTH(4)) uut (
        .clk(clk), .load_n(load_n), .din(din[3:0]), .cnt_en_n(enp_n),
        .carry_en_n(ent_n), .dir_up(dir_up), .count(lo_q), .carry_n(lo_carry_n)
    );

    ctr_updown_stage #(.WIDTH(4)) uut_hi (
        .clk(clk), .load_n(load_n), .din(din[7:4]), .cnt_en_n(enp_n),
        .carry_en_n(lo_carry_n), .dir_up(dir_up), .count(hi_q), .carry_n(hi_carry_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic ld, input logic [7:0] d, input logic p,
                        input logic t, input logic up, input string req);
        logic exp_c0, exp_c1;
        @(negedge clk);
        load_n = ld; din = d; enp_n = p; ent_n = t; dir_up = up;
        @(posedge clk);
        #1;
        if (!ld)            model = d;
        else if (!p && !t)  model = up ? model + 8'd1 : model - 8'd1;
        check({hi_q, lo_q} == model, req, int'({hi_q, lo_q}), int'(model));
        exp_c0 = !(!t && (up ? model[3:0] == 4'hF : model[3:0] == 4'h0));
        exp_c1 = !(!exp_c0 && (up ? model[7:4] == 4'hF : model[7:4] == 4'h0));
        check(lo_carry_n == exp_c0, "R7 low stage", int'(lo_carry_n), int'(exp_c0));
        check(hi_carry_n == exp_c1, "R7 R9 high stage", int'(hi_carry_n), int'(exp_c1));
    endtask

    initial begin
        // R1: every 8-bit value loaded; R2: enables alternate while loading.
        for (int v = 0; v < 256; v++) begin
            step(1'b0, 8'(v), v[1], v[2], v[0], "R1 R2 load");
        end
        step(1'b0, 8'h5A, 1'b0, 1'b0, 1'b1, "R2 load with enables low");
        step(1'b0, 8'hA5, 1'b0, 1'b1, 1'b0, "R2 load with one enable high");

        // R3 R6 R9: count up across nibble boundaries and the full wrap.
        step(1'b0, 8'hF0, 1'b1, 1'b1, 1'b1, "R1 preset");
        for (int i = 0; i < 300; i++) step(1'b1, 8'h00, 1'b0, 1'b0, 1'b1, "R3 R6 R9 up");

        // R4 R6 R9: count down across the wrap.
        step(1'b0, 8'h10, 1'b1, 1'b1, 1'b0, "R1 preset");
        for (int i = 0; i < 300; i++) step(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, "R4 R6 R9 down");

        // R5: each enable alone inhibits.
        step(1'b0, 8'h3F, 1'b0, 1'b0, 1'b1, "R1 preset");
        step(1'b1, 8'h00, 1'b1, 1'b0, 1'b1, "R5 cnt_en_n high holds");
        step(1'b1, 8'h00, 1'b0, 1'b1, 1'b1, "R5 carry_en_n high holds");
        step(1'b1, 8'h00, 1'b1, 1'b1, 1'b0, "R5 both high holds");
        step(1'b1, 8'h00, 1'b0, 1'b0, 1'b1, "R3 resume up");

        // R7: carry follows carry_en_n and dir_up with no clock edge.
        step(1'b0, 8'h0F, 1'b1, 1'b1, 1'b1, "R1 preset");
        ent_n = 1'b0; #0.3;
        check(lo_carry_n == 1'b0, "R7 carry_en_n fall at 15 up", int'(lo_carry_n), 0);
        dir_up = 1'b0; #0.3;
        check(lo_carry_n == 1'b1, "R7 dir down at 15", int'(lo_carry_n), 1);
        ent_n = 1'b1; #0.3;
        check(lo_carry_n == 1'b1, "R7 carry_en_n high", int'(lo_carry_n), 1);
        step(1'b0, 8'h00, 1'b1, 1'b1, 1'b1, "R1 preset");
        ent_n = 1'b0; #0.3;
        check(lo_carry_n == 1'b1, "R7 zero while up", int'(lo_carry_n), 1);
        dir_up = 1'b0; #0.3;
        check(lo_carry_n == 1'b0, "R7 dir down at 0", int'(lo_carry_n), 0);
        check(hi_carry_n == 1'b0, "R7 R9 chained carry at 0 down", int'(hi_carry_n), 0);

        // R8: control changes between edges do not move the count.
        step(1'b0, 8'h33, 1'b1, 1'b1, 1'b1, "R1 preset");
        load_n = 1'b0; din = 8'hCC; enp_n = 1'b0; ent_n = 1'b0; dir_up = 1'b0;
        #0.5;
        check({hi_q, lo_q} == 8'h33, "R8 mid-cycle change", int'({hi_q, lo_q}), 8'h33);
        step(1'b1, 8'h00, 1'b1, 1'b1, 1'b1, "R8 hold after glitch");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule